// File: doc/BRIEF.md
# Command/Data Port Buffer Access Controller

This block is the host-facing slave side of a peripheral whose internal word buffer cannot be addressed directly. The host reaches it through two 16-bit ports. It first writes a command code to the command port. It then streams data words one at a time through the data port until a word budget is used up. That budget comes from a separately programmed byte-count register. The direction of the whole cycle, read or write, is fixed by the command code.

A strobe decoder turns the active-low chip select, the two address lines and the read/write strobes into single-cycle events. Each event fires when the active strobe is released. A sequencer holds the byte-count register, the word pointer and the words still to go. It also keeps a done flag and a sticky error flag. The buffer RAM sits behind the sequencer.

A cycle can also run in DMA mode. The block then raises a request line. The host answers each word by pulling the acknowledge line low while strobing. Chip select and address are not used during those DMA words.

Top module: `cmdport_buffer_ctrl`

## Requirements
- R1: Reset state: `data_out`, `dma_req`, `done` and `err` are 0, and the byte-count register holds 0.
- R2: Command code layout. Bit 7 is the direction (1 = write, 0 = read), bits 6:0 are the operation and bits 15:8 are ignored. Operation 0x22 accesses the byte-count register with one data word: after command 0xA2, a data write loads it, and after command 0x22, a data read returns it on `data_out`.
- R3: Operation 0x40 is a PIO buffer cycle. After command 0xC0, data writes fill buffer words 0, 1, 2 and so on. After command 0x40, data reads return them in the same order. During a read cycle `data_out` shows the word at the current pointer. Outside any read cycle it is 0.
- R4: A buffer cycle carries ceil(count/2) words. A count of 0 gives one word, and the number of words is capped at DEPTH (64 by default).
- R5: `done` rises on the release of the strobe that completes the last word of the cycle. A new command clears it.
- R6: A data access in the wrong direction for the current cycle is ignored. It sets `err`, and the pointer does not advance.
- R7: A data access after the word budget is used up is ignored and sets `err`. The buffer contents are not changed.
- R8: A command written at any time aborts the cycle in progress. It clears `done` and `err`, resets the pointer to 0 and reloads the word count from the byte-count register.
- R9: Operation 0x41 is a DMA buffer cycle. The command raises `dma_req`. Each word moves on a strobe release while `dma_ack_n` is low, whatever the state of `cs_n` and `addr`. `dma_req` falls once the final word completes.
- R10: A PIO data access during a DMA cycle, or a DMA access during a PIO or register cycle, is ignored and sets `err`. `dma_req` stays asserted.
- R11: A strobe with `cs_n` high, or with `addr` equal to 00 or 01, has no effect and leaves `err` unchanged. The command port is selected by `addr` = 11 and the data port by `addr` = 10. After a command with an unknown operation, every data access sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Port select: 11 command, 10 data |
| rd_n | input | 1 | Read strobe, active low, acts on release |
| wr_n | input | 1 | Write strobe, active low, acts on release |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| data_in | input | 16 | Write data from host |
| data_out | output | 16 | Read data to host |
| dma_req | output | 1 | DMA request for the current cycle |
| done | output | 1 | Last word of the cycle has completed |
| err | output | 1 | Sticky flag for rejected accesses |

## Verification
Directed cases cover the following:
- byte counts of 0, odd values, even values and values above the cap, which separate the rounding, the minimum and the clamp in the word budget;
- direction, channel and over-run violations, each followed by a read-back showing that neither the pointer nor the buffer moved;
- an abort halfway through a cycle, which shows that the next word lands at location 0;
- deselected and wrong-address strobes, which show that nothing changes at all, not even `err`.

Random rounds then pick a byte count, a write channel and a read channel, fill the buffer with random words and read them back. A mismatch in the contents points to the pointer or the RAM, while a misplaced `done` or `dma_req` points to the budget.

// File: rtl/cpb_pkg.sv
// Shared types and command encodings for the command/data port buffer
// controller. Assumes 16-bit host words and a 7-bit operation field.
package cpb_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'd0,
        MODE_COUNT = 2'd1,
        MODE_BUF   = 2'd2
    } mode_t;

    localparam logic [6:0] OP_COUNT   = 7'h22;
    localparam logic [6:0] OP_BUF_PIO = 7'h40;
    localparam logic [6:0] OP_BUF_DMA = 7'h41;

    typedef struct packed {
        logic cmd_wr;
        logic pio_wr;
        logic pio_rd;
        logic dma_wr;
        logic dma_rd;
    } bus_evt_t;

endpackage

// File: rtl/cpb_strobe_decode.sv
// Turns host strobes into one-cycle events on their release edge.
// Assumes the host never asserts rd_n and wr_n together and holds
// cs_n, addr, dma_ack_n and data_in stable until one clock after release.
module cpb_strobe_decode
    import cpb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic [1:0] addr,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       dma_ack_n,
    output bus_evt_t   evt
);

    logic rd_q, wr_q;
    logic wr_rel, rd_rel, cmd_sel, dat_sel, dma_sel;

    // Remember the previous strobe levels for release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b1;
            wr_q <= 1'b1;
        end else begin
            rd_q <= rd_n;
            wr_q <= wr_n;
        end
    end

    // Classify a release by port and channel.
    always_comb begin
        wr_rel     = wr_n & ~wr_q;
        rd_rel     = rd_n & ~rd_q;
        dma_sel    = ~dma_ack_n;
        cmd_sel    = ~cs_n & dma_ack_n & (addr == 2'b11);
        dat_sel    = ~cs_n & dma_ack_n & (addr == 2'b10);
        evt.cmd_wr = wr_rel & cmd_sel;
        evt.pio_wr = wr_rel & dat_sel;
        evt.pio_rd = rd_rel & dat_sel;
        evt.dma_wr = wr_rel & dma_sel;
        evt.dma_rd = rd_rel & dma_sel;
    end

    // R11: one release never yields two events.
    assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_n | wr_n) |-> $onehot0(evt));

endmodule

// File: rtl/cpb_buffer_ram.sv
// Word buffer: synchronous write, combinational read.
// Assumes a single writer; depth is a parameter.
module cpb_buffer_ram #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a word on write enable.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Present the addressed word.
    assign rdata = mem[addr];

endmodule

// File: rtl/cpb_sequencer.sv
// Command decode, byte-count register, word budget, pointer and flags.
// Assumes at most one bus event per cycle (guaranteed by the decoder).
module cpb_sequencer
    import cpb_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int WL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_evt_t          evt,
    input  logic [DATA_W-1:0] din,
    output logic              ram_we,
    output logic [PTR_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] count_q,
    output mode_t             mode,
    output logic              dir_wr,
    output logic              dma_req,
    output logic              done,
    output logic              err
);

    logic             dma_q;
    logic [PTR_W-1:0] ptr;
    logic [WL_W-1:0]  words_left;
    logic [WL_W-1:0]  wl_load;
    logic [DATA_W:0]  half;
    logic             acc_wr, acc_rd, acc_dma, acc_any;
    logic             chan_ok, dir_ok, accept;
    logic [6:0]       op;

    // Word budget from the byte count: round up, at least one, at most DEPTH.
    always_comb begin
        half = ({1'b0, count_q} + 1'b1) >> 1;
        if (half == '0)
            wl_load = WL_W'(1);
        else if (half > (DATA_W+1)'(DEPTH))
            wl_load = WL_W'(DEPTH);
        else
            wl_load = WL_W'(half);
    end

    // Decide whether a data access belongs to the current cycle.
    always_comb begin
        acc_wr  = evt.pio_wr | evt.dma_wr;
        acc_rd  = evt.pio_rd | evt.dma_rd;
        acc_dma = evt.dma_wr | evt.dma_rd;
        acc_any = acc_wr | acc_rd;
        chan_ok = (mode == MODE_BUF && dma_q) ? acc_dma : ~acc_dma;
        dir_ok  = dir_wr ? acc_wr : acc_rd;
        accept  = acc_any & chan_ok & dir_ok & (words_left != '0);
        op      = din[6:0];
    end

    assign ram_we   = accept & (mode == MODE_BUF) & dir_wr;
    assign ram_addr = ptr;

    // Cycle state: command load, word stepping and flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MODE_IDLE;
            dir_wr     <= 1'b0;
            dma_q      <= 1'b0;
            ptr        <= '0;
            words_left <= '0;
            count_q    <= '0;
            dma_req    <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else if (evt.cmd_wr) begin
            dir_wr <= din[7];
            ptr    <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            if (op == OP_COUNT) begin
                mode       <= MODE_COUNT;
                words_left <= WL_W'(1);
                dma_q      <= 1'b0;
                dma_req    <= 1'b0;
            end else if (op[6:1] == OP_BUF_PIO[6:1]) begin
                mode       <= MODE_BUF;
                words_left <= wl_load;
                dma_q      <= op[0];
                dma_req    <= op[0];
            end else begin
                mode       <= MODE_IDLE;
                words_left <= '0;
                dma_q      <= 1'b0;
                dma_req    <= 1'b0;
            end
        end else if (acc_any) begin
            if (accept) begin
                ptr        <= ptr + 1'b1;
                words_left <= words_left - 1'b1;
                if (mode == MODE_COUNT && dir_wr) count_q <= din;
                if (words_left == WL_W'(1)) begin
                    done    <= 1'b1;
                    dma_req <= 1'b0;
                end
            end else begin
                err <= 1'b1;
            end
        end
    end

    // R5: done only once the budget is spent.
    assert_done_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (words_left == '0));

    // R6: a rejection leaves pointer and budget where they were.
    assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($stable(ptr) && $stable(words_left)));

    // R7: the budget never grows without a command.
    assert_budget_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !evt.cmd_wr |=> (words_left <= $past(words_left)));

    // R8: a command restarts the cycle cleanly.
    assert_cmd_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt.cmd_wr |=> (ptr == '0 && !done && !err));

    // R9: request only inside an unfinished DMA buffer cycle.
    assert_req_in_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (mode == MODE_BUF && dma_q && words_left != '0));

    // R6: err is sticky until the next command.
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !evt.cmd_wr) |=> err);

endmodule

// File: rtl/cmdport_buffer_ctrl.sv
// Top: host command/data port access to an internal word buffer.
// Assumes the host honours the strobe hold rules of cpb_strobe_decode.
module cmdport_buffer_ctrl
    import cpb_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [1:0]        addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              dma_ack_n,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              dma_req,
    output logic              done,
    output logic              err
);

    localparam int PTR_W = $clog2(DEPTH);

    bus_evt_t          evt;
    logic              ram_we;
    logic [PTR_W-1:0]  ram_addr;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] count_q;
    mode_t             mode;
    logic              dir_wr;

    cpb_strobe_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .addr      (addr),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .dma_ack_n (dma_ack_n),
        .evt       (evt)
    );

    cpb_sequencer #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .din      (data_in),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .count_q  (count_q),
        .mode     (mode),
        .dir_wr   (dir_wr),
        .dma_req  (dma_req),
        .done     (done),
        .err      (err)
    );

    cpb_buffer_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (data_in),
        .rdata (ram_rdata)
    );

    // Read data source for the current read cycle, zero otherwise.
    always_comb begin
        if (mode == MODE_COUNT && !dir_wr)
            data_out = count_q;
        else if (mode == MODE_BUF && !dir_wr)
            data_out = ram_rdata;
        else
            data_out = '0;
    end

    // R1: nothing is requested or flagged in the cycle after reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!dma_req && !done && !err && data_out == '0));

endmodule

// File: tb/tb_cmdport_buffer_ctrl.sv
module tb_cmdport_buffer_ctrl;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic [1:0]  addr = 2'b00;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        dma_ack_n = 1'b1;
    logic [15:0] data_in = '0;
    logic [15:0] data_out;
    logic        dma_req, done, err;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model [DEPTH];

    always #10 clk = ~clk;

    cmdport_buffer_ctrl #(.DEPTH(DEPTH), .DATA_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .rd_n(rd_n),
        .wr_n(wr_n), .dma_ack_n(dma_ack_n), .data_in(data_in),
        .data_out(data_out), .dma_req(dma_req), .done(done), .err(err)
    );

    function automatic int exp_words(input int cnt);
        int w;
        w = (cnt + 1) / 2;
        if (w < 1) w = 1;
        if (w > DEPTH) w = DEPTH;
        return w;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic strobe_wr(input logic c_n, input logic [1:0] a, input logic dma, input logic [15:0] d);
        @(negedge clk);
        cs_n = c_n; addr = a; dma_ack_n = ~dma; data_in = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; dma_ack_n = 1'b1; addr = 2'b00;
    endtask

    task automatic strobe_rd(input logic c_n, input logic [1:0] a, input logic dma, output logic [15:0] d);
        @(negedge clk);
        cs_n = c_n; addr = a; dma_ack_n = ~dma; rd_n = 1'b0;
        @(negedge clk);
        d = data_out;
        rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; dma_ack_n = 1'b1; addr = 2'b00;
    endtask

    task automatic cmd(input logic [15:0] c);
        strobe_wr(1'b0, 2'b11, 1'b0, c);
    endtask

    task automatic set_count(input logic [15:0] n);
        cmd(16'h00A2);
        strobe_wr(1'b0, 2'b10, 1'b0, n);
    endtask

    task automatic put(input logic dma, input logic [15:0] d);
        strobe_wr(1'b0, 2'b10, dma, d);
    endtask

    task automatic get(input logic dma, output logic [15:0] d);
        strobe_rd(1'b0, 2'b10, dma, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 data_out", data_out, 0);
        check("R1 dma_req", dma_req, 0);
        check("R1 done", done, 0);
        check("R1 err", err, 0);
        cmd(16'h0022); get(1'b0, rv);
        check("R1 count after reset", rv, 0);

        // R2 count register round trip, upper byte of command ignored
        set_count(16'h1236);
        cmd(16'h5522); get(1'b0, rv);
        check("R2 count readback", rv, 16'h1236);

        // R3/R4/R5 even count of 6 bytes = 3 words
        set_count(16'd6);
        cmd(16'h00C0);
        for (int i = 0; i < 3; i++) begin
            model[i] = 16'hA000 + 16'(i);
            put(1'b0, model[i]);
            check("R5 done timing", done, (i == 2) ? 1 : 0);
        end
        cmd(16'h0040);
        check("R5 done cleared by command", done, 0);
        for (int i = 0; i < 3; i++) begin
            get(1'b0, rv);
            check("R3 sequential read", rv, model[i]);
        end
        check("R4 three words then done", done, 1);
        cmd(16'h00C0);
        check("R3 data_out zero in write cycle", data_out, 0);

        // R4 odd count of 5 bytes = 3 words
        set_count(16'd5);
        cmd(16'h00C0);
        for (int i = 0; i < 3; i++) put(1'b0, 16'hB000 + 16'(i));
        check("R4 odd count rounds up", done, 1);
        model[0] = 16'hB000; model[1] = 16'hB001; model[2] = 16'hB002;

        // R4/R7 zero count = one word, then an over-run
        set_count(16'd0);
        cmd(16'h00C0);
        put(1'b0, 16'hC0DE);
        model[0] = 16'hC0DE;
        check("R4 zero count is one word", done, 1);
        check("R7 no err before over-run", err, 0);
        put(1'b0, 16'hDEAD);
        check("R7 over-run sets err", err, 1);
        set_count(16'd4);
        cmd(16'h0040);
        get(1'b0, rv);
        check("R7 over-run left buffer intact", rv, 16'hC0DE);
        get(1'b0, rv);
        check("R7 location 1 intact", rv, 16'hB001);

        // R6 wrong direction
        cmd(16'h0040);
        put(1'b0, 16'h7777);
        check("R6 wrong direction sets err", err, 1);
        get(1'b0, rv);
        check("R6 pointer did not advance", rv, 16'hC0DE);

        // R8 abort mid-cycle
        set_count(16'd8);
        cmd(16'h00C0);
        put(1'b0, 16'h1111); put(1'b0, 16'h2222);
        cmd(16'h00C0);
        put(1'b0, 16'h3333);
        check("R8 done clear after restart", done, 0);
        cmd(16'h0040);
        get(1'b0, rv); check("R8 restart wrote location 0", rv, 16'h3333);
        get(1'b0, rv); check("R8 location 1 kept", rv, 16'h2222);

        // R9 DMA write then DMA read
        set_count(16'd4);
        cmd(16'h00C1);
        check("R9 request raised", dma_req, 1);
        strobe_wr(1'b1, 2'b00, 1'b1, 16'h4444);
        check("R9 request held mid-cycle", dma_req, 1);
        strobe_wr(1'b1, 2'b00, 1'b1, 16'h5555);
        check("R9 request dropped after last", dma_req, 0);
        check("R9 done after last", done, 1);
        cmd(16'h0041);
        check("R9 request raised for read", dma_req, 1);
        strobe_rd(1'b1, 2'b00, 1'b1, rv); check("R9 dma read 0", rv, 16'h4444);
        strobe_rd(1'b1, 2'b00, 1'b1, rv); check("R9 dma read 1", rv, 16'h5555);
        check("R9 read request dropped", dma_req, 0);

        // R10 channel mismatch
        cmd(16'h00C1);
        put(1'b0, 16'h9999);
        check("R10 PIO in DMA cycle sets err", err, 1);
        check("R10 request kept", dma_req, 1);
        cmd(16'h00C0);
        put(1'b1, 16'h9999);
        check("R10 DMA in PIO cycle sets err", err, 1);

        // R11 deselected and wrong-address strobes
        cmd(16'h00C0);
        strobe_wr(1'b1, 2'b10, 1'b0, 16'hEEEE);
        strobe_wr(1'b0, 2'b00, 1'b0, 16'hEEEE);
        strobe_wr(1'b0, 2'b01, 1'b0, 16'hEEEE);
        strobe_rd(1'b0, 2'b11, 1'b0, rv);
        check("R11 ignored strobes leave err", err, 0);
        put(1'b0, 16'h6060);
        cmd(16'h0040);
        get(1'b0, rv);
        check("R11 next write went to location 0", rv, 16'h6060);
        cmd(16'h0015);
        put(1'b0, 16'h0001);
        check("R11 unknown op errs data access", err, 1);

        // R4 clamp at DEPTH
        set_count(16'd300);
        cmd(16'h00C0);
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = 16'(i * 7 + 3);
            put(1'b0, model[i]);
            if (i == DEPTH - 2) check("R4 not done before cap", done, 0);
        end
        check("R4 done at cap", done, 1);

        // R3/R9 random rounds
        for (int it = 0; it < 30; it++) begin
            int cnt, w;
            logic wdma, rdma;
            cnt  = $urandom_range(0, 140);
            w    = exp_words(cnt);
            wdma = 1'($urandom_range(0, 1));
            rdma = 1'($urandom_range(0, 1));
            set_count(16'(cnt));
            cmd({8'h00, 1'b1, 6'h20, wdma});
            for (int i = 0; i < w; i++) begin
                model[i] = 16'($urandom);
                put(wdma, model[i]);
            end
            check("R5 random write done", done, 1);
            check("R9 random write req", dma_req, 0);
            if (it % 5 == 0) begin
                put(wdma, 16'hFFFF);
                check("R7 random over-run", err, 1);
            end
            cmd({8'h00, 1'b0, 6'h20, rdma});
            for (int i = 0; i < w; i++) begin
                get(rdma, rv);
                check("R3 random readback", rv, model[i]);
            end
            check("R5 random read done", done, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule